// File: doc/BRIEF.md
# Flash Write-Completion Poller

This engine runs on the host side of a flash device after a program or erase command. Once the command issuer has finished its last write pulse, it pulses `start_i` with the operation type, an address to poll, the data that was written, and a limit on the number of polling reads. The engine then reads that address repeatedly over a read request/response stream. It watches the status bit (bit 7) of each returned word. During a program operation that bit reads back inverted until the device finishes. During an erase it reads 0 until the device finishes.

A status match does not end the operation. The bit can settle before the rest of the word does, so the engine always issues one more read and takes that word as the final array data. For a program operation the whole confirming word must equal the written data. If the confirming read no longer shows a match, the engine goes back to polling. A count of missed polls ends a stuck operation with a timeout. For erase, the polled address must lie inside a sector that is being erased and is not protected; that choice is the caller's.

Read requests use valid/ready. `req_valid_o` stays high with a stable address until `req_ready_i` is seen, and the device may stall for any number of cycles. Responses are accepted only while `rsp_ready_o` is high. At most one read is outstanding.

Top module: `flash_poll_engine`

## Requirements
- R1: After reset, busy_o, done_o, pass_o, timeout_o, req_valid_o and rsp_ready_o are all 0.
- R2: A read request holds req_valid_o and req_addr_o steady until accepted, and always carries the address latched at start. Only one read is outstanding: rsp_ready_o is high only while a response is awaited, and never together with req_valid_o.
- R3: For a program operation, a polling read whose bit 7 differs from bit 7 of the written data counts as busy and is followed by another polling read.
- R4: For an erase operation, a polling read with bit 7 = 0 counts as busy, and bit 7 = 1 counts as a status match.
- R5: A polling read that matches never ends the operation; exactly one confirming read follows it.
- R6: If the confirming read matches on bit 7, the operation ends. For a program operation, pass_o is 1 only if all 32 bits equal the written data, and otherwise pass_o and timeout_o are both 0. An erase operation passes.
- R7: If the confirming read does not match on bit 7, polling resumes, and that read counts as one missed poll.
- R8: When the number of missed polls reaches the limit (a limit of 0 acts as 1), the operation ends with timeout_o = 1 and pass_o = 0, and no further read is issued.
- R9: start_i is ignored while busy_o is 1.
- R10: done_o is a one-cycle pulse and busy_o drops in the same cycle. final_data_o then holds the word of the last read, and pass_o, timeout_o and final_data_o hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| op_erase_i | input | 1 | 1 = erase operation, 0 = program operation |
| target_addr_i | input | ADDR_W | Address to poll |
| write_data_i | input | DATA_W | Data that was written (program) |
| poll_limit_i | input | CNT_W | Maximum number of missed polls |
| req_valid_o | output | 1 | Read request valid |
| req_ready_i | input | 1 | Read request accepted |
| req_addr_o | output | ADDR_W | Read request address |
| rsp_valid_i | input | 1 | Read response valid |
| rsp_ready_o | output | 1 | Engine can take a response |
| rsp_data_i | input | DATA_W | Read response word |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| pass_o | output | 1 | Operation finished correctly |
| timeout_o | output | 1 | Operation ended by the poll limit |
| final_data_o | output | DATA_W | Word of the last read |

## Verification
The bench targets several corner cases:
- A status match on the very first read. A design that skips the confirming read reports done one read early.
- A confirming read that matches on bit 7 but differs in a lower bit. A lax design would pass it.
- A confirming read that flips back to busy. It must re-enter polling and count toward the limit, and a design that stopped there or ignored the miss would show the wrong read count or verdict.
- Limits of 0 and small values, where an off-by-one shows up as one read too many or too few.
- A start pulse with a different address in the middle of an operation. A design that re-latched it would send reads to the wrong address.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fpe_state_e;

  typedef enum logic {
    PH_POLL    = 1'b0,
    PH_CONFIRM = 1'b1
  } fpe_phase_e;
endpackage

// File: rtl/fpe_status_eval.sv
module fpe_status_eval #(
  parameter int DATA_W   = 32,
  parameter int FLAG_BIT = 7
) (
  input  logic [DATA_W-1:0] rsp_word_i,
  input  logic [DATA_W-1:0] written_i,
  input  logic              erase_i,
  output logic              flag_ok_o,
  output logic              word_ok_o
);
  // erase completes when the flag reads 1; program when it equals the written bit
  logic ref_flag;
  assign ref_flag  = erase_i ? 1'b1 : written_i[FLAG_BIT];
  assign flag_ok_o = (rsp_word_i[FLAG_BIT] == ref_flag);
  assign word_ok_o = (rsp_word_i == written_i);
endmodule

// File: rtl/fpe_poll_counter.sv
module fpe_poll_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             bump_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   next_cnt;

  assign next_cnt = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  // a zero limit still allows one polling read
  assign last_o   = next_cnt >= {1'b0, limit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (bump_i)  cnt_q <= next_cnt[CNT_W-1:0];
  end
endmodule

// File: rtl/flash_poll_engine.sv
module flash_poll_engine #(
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 20,
  parameter int CNT_W    = 16,
  parameter int FLAG_BIT = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic [ADDR_W-1:0] target_addr_i,
  input  logic [DATA_W-1:0] write_data_i,
  input  logic [CNT_W-1:0]  poll_limit_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [ADDR_W-1:0] req_addr_o,
  input  logic              rsp_valid_i,
  output logic              rsp_ready_o,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              pass_o,
  output logic              timeout_o,
  output logic [DATA_W-1:0] final_data_o
);
  import fpe_pkg::*;

  fpe_state_e        state_q;
  fpe_phase_e        phase_q;
  logic              erase_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [CNT_W-1:0]  limit_q;
  logic              done_q, pass_q, timeout_q;
  logic [DATA_W-1:0] final_q;

  logic take_start, rsp_fire, flag_ok, word_ok, miss, cnt_last;
  logic finish_ok, finish_to;

  assign take_start = (state_q == ST_IDLE) && start_i;
  assign rsp_fire   = (state_q == ST_WAIT) && rsp_valid_i;
  assign miss       = rsp_fire && !flag_ok;
  assign finish_ok  = rsp_fire && flag_ok && (phase_q == PH_CONFIRM);
  assign finish_to  = miss && cnt_last;

  fpe_status_eval #(.DATA_W(DATA_W), .FLAG_BIT(FLAG_BIT)) u_eval (
    .rsp_word_i (rsp_data_i),
    .written_i  (wdata_q),
    .erase_i    (erase_q),
    .flag_ok_o  (flag_ok),
    .word_ok_o  (word_ok)
  );

  fpe_poll_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (take_start),
    .bump_i  (miss),
    .limit_i (limit_q),
    .last_o  (cnt_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= PH_POLL;
      erase_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      limit_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          erase_q <= op_erase_i;
          addr_q  <= target_addr_i;
          wdata_q <= write_data_i;
          limit_q <= poll_limit_i;
          phase_q <= PH_POLL;
          state_q <= ST_REQ;
        end
        ST_REQ: if (req_ready_i) state_q <= ST_WAIT;
        ST_WAIT: if (rsp_valid_i) begin
          if (finish_ok || finish_to) begin
            state_q <= ST_IDLE;
          end else begin
            state_q <= ST_REQ;
            phase_q <= (flag_ok && phase_q == PH_POLL) ? PH_CONFIRM : PH_POLL;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q    <= 1'b0;
      pass_q    <= 1'b0;
      timeout_q <= 1'b0;
      final_q   <= '0;
    end else begin
      done_q <= finish_ok || finish_to;
      if (take_start) begin
        pass_q    <= 1'b0;
        timeout_q <= 1'b0;
      end
      if (finish_ok) pass_q    <= erase_q || word_ok;
      if (finish_to) timeout_q <= 1'b1;
      if (finish_ok || finish_to) final_q <= rsp_data_i;
    end
  end

  assign req_valid_o  = (state_q == ST_REQ);
  assign req_addr_o   = addr_q;
  assign rsp_ready_o  = (state_q == ST_WAIT);
  assign busy_o       = (state_q != ST_IDLE);
  assign done_o       = done_q;
  assign pass_o       = pass_q;
  assign timeout_o    = timeout_q;
  assign final_data_o = final_q;
endmodule

// File: rtl/fpe_checker.sv
module fpe_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic [ADDR_W-1:0] target_addr_i,
  input logic              req_valid_o,
  input logic              req_ready_i,
  input logic [ADDR_W-1:0] req_addr_o,
  input logic              rsp_ready_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              pass_o,
  input logic              timeout_o
);
  logic [ADDR_W-1:0] seen_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  seen_addr <= '0;
    else if (start_i && !busy_o) seen_addr <= target_addr_i;
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!req_valid_o && !rsp_ready_o));

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o)));

  assert_single_outstanding_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_o && rsp_ready_o));

  assert_addr_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid_o |-> (req_addr_o == seen_addr));

  assert_verdict_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !(pass_o && timeout_o));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_busy_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

bind flash_poll_engine fpe_checker #(.ADDR_W(ADDR_W)) u_fpe_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .start_i       (start_i),
  .target_addr_i (target_addr_i),
  .req_valid_o   (req_valid_o),
  .req_ready_i   (req_ready_i),
  .req_addr_o    (req_addr_o),
  .rsp_ready_o   (rsp_ready_o),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .pass_o        (pass_o),
  .timeout_o     (timeout_o)
);

// File: tb/flash_poll_engine_bench.sv
`timescale 1ns/1ps
module flash_poll_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_erase_i = 1'b0;
  logic [19:0] target_addr_i = '0;
  logic [31:0] write_data_i = '0;
  logic [15:0] poll_limit_i = '0;
  logic        req_valid_o, req_ready_i, rsp_ready_o;
  logic [19:0] req_addr_o;
  logic        rsp_valid_i = 1'b0;
  logic [31:0] rsp_data_i = '0;
  logic        busy_o, done_o, pass_o, timeout_o;
  logic [31:0] final_data_o;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk;

  flash_poll_engine u_flash_poll_engine (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_erase_i(op_erase_i),
    .target_addr_i(target_addr_i), .write_data_i(write_data_i),
    .poll_limit_i(poll_limit_i), .req_valid_o(req_valid_o),
    .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .rsp_valid_i(rsp_valid_i), .rsp_ready_o(rsp_ready_o),
    .rsp_data_i(rsp_data_i), .busy_o(busy_o), .done_o(done_o),
    .pass_o(pass_o), .timeout_o(timeout_o), .final_data_o(final_data_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // device model: responds to reads from a preloaded word list
  logic [31:0] dev_q[$];
  logic [31:0] dev_busy = '0;
  logic [19:0] dev_addr = '0;
  int          dev_reads = 0;
  int          cyc = 0;
  bit          pend = 0;
  int          dly = 0;
  bit          fired_req = 0, fired_rsp = 0;

  initial begin
    req_ready_i = 1'b0;
    forever begin
      @(negedge clk);
      cyc++;
      if (fired_rsp) begin rsp_valid_i = 1'b0; pend = 0; end
      if (fired_req) begin
        dev_reads++;
        chk("R2 read address", {12'h0, req_addr_o}, {12'h0, dev_addr});
        pend = 1; dly = 2;
      end
      req_ready_i = (cyc % 3) != 1;
      if (pend && !rsp_valid_i) begin
        if (dly == 0) begin
          rsp_valid_i = 1'b1;
          rsp_data_i = (dev_q.size() > 0) ? dev_q.pop_front() : dev_busy;
        end else dly--;
      end
      fired_req = req_valid_o && req_ready_i;
      fired_rsp = rsp_valid_i && rsp_ready_o;
    end
  end

  typedef struct {
    bit          pass;
    bit          to;
    logic [31:0] fin;
    int          reads;
    string       tag;
  } exp_t;
  exp_t exp_q[$];
  int   done_seen = 0;

  // monitor: compare each completion against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (done_o) begin
        exp_t e;
        e = exp_q.pop_front();
        chk({e.tag, " pass"},    {31'h0, pass_o},    {31'h0, e.pass});
        chk({e.tag, " timeout"}, {31'h0, timeout_o}, {31'h0, e.to});
        chk({e.tag, " final word R10"}, final_data_o, e.fin);
        chk({e.tag, " read count R5"}, dev_reads, e.reads);
        chk("R10 busy drops with done", {31'h0, busy_o}, 32'h0);
        done_seen++;
      end
    end
  end

  task automatic run_op(input string tag, input bit er, input logic [19:0] a,
                        input logic [31:0] wd, input logic [15:0] lim,
                        input logic [31:0] ws[$], input bit poke);
    exp_t e;
    logic [31:0] w, busyw;
    bit m, ph;
    int cnt, n, prev;
    busyw = er ? 32'h0 : (wd ^ 32'h80);
    n = (lim == 0) ? 1 : int'(lim);
    e.pass = 0; e.to = 0; e.fin = '0; e.reads = 0; e.tag = tag;
    ph = 0; cnt = 0;
    for (int i = 0; i < 1000; i++) begin
      w = (i < ws.size()) ? ws[i] : busyw;
      e.reads++;
      m = er ? w[7] : (w[7] == wd[7]);
      if (ph && m) begin e.pass = er ? 1'b1 : (w == wd); e.fin = w; break; end
      if (!ph && m) ph = 1;
      else begin
        ph = 0; cnt++;
        if (cnt >= n) begin e.to = 1; e.fin = w; break; end
      end
    end
    exp_q.push_back(e);
    dev_q = ws; dev_busy = busyw; dev_addr = a; dev_reads = 0;
    prev = done_seen;
    @(negedge clk);
    op_erase_i = er; target_addr_i = a; write_data_i = wd; poll_limit_i = lim;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke) begin
      repeat (3) @(negedge clk);
      // R9: restart attempt while busy with different inputs
      target_addr_i = a ^ 20'h5A5A5; write_data_i = ~wd; op_erase_i = ~er;
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (done_seen == prev) @(negedge clk);
    repeat (3) @(negedge clk);
    chk({tag, " R10 pass held"},    {31'h0, pass_o},    {31'h0, e.pass});
    chk({tag, " R10 timeout held"}, {31'h0, timeout_o}, {31'h0, e.to});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R10 watchdog: actual=no-done expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 busy",      {31'h0, busy_o},      32'h0);
    chk("R1 done",      {31'h0, done_o},      32'h0);
    chk("R1 pass",      {31'h0, pass_o},      32'h0);
    chk("R1 timeout",   {31'h0, timeout_o},   32'h0);
    chk("R1 req_valid", {31'h0, req_valid_o}, 32'h0);
    chk("R1 rsp_ready", {31'h0, rsp_ready_o}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after release", {30'h0, busy_o, req_valid_o}, 32'h0);

    // R3 program, busy reads then match + confirm, with a restart attempt (R9)
    run_op("R3 R9 program busy then done", 1'b0, 20'h01234, 32'h1234_5680, 16'd20,
           '{32'h0000_0000, 32'h1234_5600, 32'hFFFF_FF7F, 32'h1234_5680, 32'h1234_5680}, 1'b1);
    // R6 program confirm matches bit 7 but word differs
    run_op("R6 program word mismatch", 1'b0, 20'h00100, 32'h0000_0011, 16'd8,
           '{32'h0000_0080, 32'h0000_0011, 32'h0000_0010}, 1'b0);
    // R5 immediate match still needs a confirming read
    run_op("R5 program immediate", 1'b0, 20'hABCDE, 32'hCAFE_00F0, 16'd4,
           '{32'hCAFE_00F0, 32'hCAFE_00F0}, 1'b0);
    // R4 erase
    run_op("R4 erase busy then done", 1'b1, 20'h40000, 32'h0, 16'd10,
           '{32'h0000_0000, 32'h0000_0000, 32'h0000_0080, 32'hFFFF_FFFF}, 1'b0);
    // R7 confirm flips back to busy, polling resumes
    run_op("R7 erase confirm relapse", 1'b1, 20'h40010, 32'h0, 16'd10,
           '{32'h0000_0080, 32'h0000_0000, 32'h0000_0080, 32'hFFFF_FFFF}, 1'b0);
    // R7 R8 relapse counts toward the limit
    run_op("R7 R8 relapse hits limit", 1'b1, 20'h40020, 32'h0, 16'd2,
           '{32'h0000_0080, 32'h0000_0000, 32'h0000_0001}, 1'b0);
    // R8 timeout with limit 4
    run_op("R8 program timeout", 1'b0, 20'h00777, 32'h0000_0080, 16'd4,
           '{32'h1, 32'h2, 32'h3, 32'h4}, 1'b0);
    // R8 limit 0 acts as 1
    run_op("R8 zero limit", 1'b1, 20'h00888, 32'h0, 16'd0, '{32'h0000_0042}, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule